// File: doc/BRIEF.md
# Bounded Request-Response Latency Monitor

This block watches two strobe streams, one for requests and one for responses. Each strobe carries a timestamp. The monitor pairs them purely by arrival count: the k-th response belongs to the k-th request. It raises a sticky violation flag whenever a pair's latency (response timestamp minus request timestamp, modulo the timestamp width) is not below a bound. Request timestamps wait in a circular store of fixed depth until their response arrives.

The store is finite, so a long burst of unanswered requests can exhaust it. In that case the monitor can no longer say whether the latency property holds. It latches an overflow flag and stops judging latency. The verdict then becomes inconclusive rather than a false pass. A violation seen before overflow still yields an unsatisfied verdict. A response that has no request to pair with raises a separate protocol-error flag.

The block is meant to sit beside a datapath in simulation or emulation, fed by the strobes of the transaction it supervises.

Top module: `lat_pair_mon`

## Requirements
- R1: After reset, `lat_viol`, `ovf_flag` and `proto_err` are 0 and `verdict` is 2'b00 (satisfied). Verdict encoding: 2'b00 satisfied, 2'b01 inconclusive, 2'b10 unsatisfied.
- R2: With the default bound of 25 and inclusive mode off, a pair whose latency is 24 or less leaves `lat_viol` at 0. A pair whose latency is 25 sets `lat_viol` at the clock edge that samples the response.
- R3: Responses pair with requests strictly in arrival order, also when several requests are outstanding.
- R4: A request and a response in the same cycle are handled request first. With nothing outstanding they form a pair of latency `rsp_ts - req_ts`. With requests outstanding, the response pairs with the oldest one.
- R5: Latency is computed modulo 2^TS_W, so a timestamp that wraps past zero yields the small true difference.
- R6: A request that arrives while DEPTH-1 (default 50) requests are outstanding sets `ovf_flag`. With no violation seen, `verdict` then reads 2'b01.
- R7: Once `ovf_flag` is set, responses no longer set `lat_viol`, whatever their latency.
- R8: A violation recorded before overflow keeps `verdict` at 2'b10 after overflow.
- R9: A response with no outstanding request and no request in the same cycle sets `proto_err`. It consumes no stored entry, so later pairs still pair correctly.
- R10: `lat_viol`, `ovf_flag` and `proto_err` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 1 | Request occurrence strobe |
| req_ts | input | TS_W | Timestamp of the request |
| rsp_stb | input | 1 | Response occurrence strobe |
| rsp_ts | input | TS_W | Timestamp of the response |
| lat_viol | output | 1 | Sticky latency violation |
| ovf_flag | output | 1 | Sticky store overflow (inconclusive) |
| proto_err | output | 1 | Sticky unmatched-response error |
| verdict | output | 2 | 00 satisfied, 01 inconclusive, 10 unsatisfied |

## Verification
The assertions assume that strobes and timestamps are clean at each sampling edge. They also assume that the timestamp of a response is never older than that of its paired request. Under that assumption a rise of any flag can be traced to a strobe in the previous cycle.

The stimulus changes inputs only on falling edges and keeps response timestamps at or after their paired request's timestamp, except across a deliberate wrap. It produces an unmatched response only in the cycle meant to test the protocol-error flag.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;

   typedef enum logic [1:0] {
      VERD_SAT     = 2'b00,
      VERD_INCONCL = 2'b01,
      VERD_UNSAT   = 2'b10
   } verdict_e;

   // Three-way outcome: a seen violation dominates, then lost pairing.
   function automatic verdict_e pick_verdict(input logic viol, input logic ovf);
      if (viol)     return VERD_UNSAT;
      else if (ovf) return VERD_INCONCL;
      else          return VERD_SAT;
   endfunction

endpackage

// File: rtl/lmon_ts_ring.sv
// Circular store of request timestamps, written in arrival order and read oldest first.
module lmon_ts_ring #(
   parameter int TS_W  = 16,
   parameter int DEPTH = 51
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [TS_W-1:0] wr_ts,
   input  logic            rd_en,
   output logic [TS_W-1:0] rd_ts
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [TS_W-1:0]  slot_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q, wp_nxt, rp_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nxt = wp_q + 1'b1;
         assign rp_nxt = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nxt = (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
         assign rp_nxt = (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_en) wp_q <= wp_nxt;
         if (rd_en) rp_q <= rp_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wp_q] <= wr_ts;
   end

   assign rd_ts = slot_q[rp_q];

   initial begin
      depth_param_chk: assert (DEPTH >= 2)
         else $error("lmon_ts_ring: DEPTH must be at least 2");
      width_param_chk: assert (TS_W >= 2)
         else $error("lmon_ts_ring: TS_W must be at least 2");
   end

endmodule

// File: rtl/lmon_pair_track.sv
// Counts outstanding requests and decides matching, overflow and protocol error.
module lmon_pair_track #(
   parameter int DEPTH = 51
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_stb,
   input  logic rsp_stb,
   output logic rsp_ok,
   output logic rsp_bypass,
   output logic ovf_q,
   output logic proto_q
);
   localparam int CNT_W = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH-1);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             empty, ovf_hit, proto_hit;

   assign empty      = (cnt_q == '0);
   // Same-cycle request is taken first, so it can serve an otherwise empty store.
   assign rsp_ok     = rsp_stb && (!empty || req_stb);
   assign rsp_bypass = rsp_stb && empty && req_stb;
   assign proto_hit  = rsp_stb && empty && !req_stb;
   assign ovf_hit    = req_stb && (cnt_q == CNT_MAX);

   always_comb begin
      cnt_nxt = cnt_q;
      if (req_stb && !rsp_ok) begin
         if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
      end else if (!req_stb && rsp_ok) begin
         cnt_nxt = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
         proto_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         if (ovf_hit)   ovf_q   <= 1'b1;
         if (proto_hit) proto_q <= 1'b1;
      end
   end

   // R6
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(req_stb));
   // R9
   proto_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proto_q) |-> $past(rsp_stb && !req_stb));
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
   // R10
   proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_q |=> proto_q);

   initial begin
      cnt_param_chk: assert (DEPTH >= 2)
         else $error("lmon_pair_track: DEPTH must be at least 2");
   end

endmodule

// File: rtl/lmon_lat_judge.sv
// Latency comparison and the sticky violation record.
module lmon_lat_judge #(
   parameter int TS_W       = 16,
   parameter int LAT_BOUND  = 25,
   parameter bit INCL_BOUND = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            chk_en,
   input  logic            ovf_q,
   input  logic [TS_W-1:0] ref_ts,
   input  logic [TS_W-1:0] rsp_ts,
   output logic            viol_q
);
   localparam logic [TS_W-1:0] BOUND = TS_W'(LAT_BOUND);

   logic [TS_W-1:0] lat;
   logic            too_late;

   // Modular difference handles timestamp wrap.
   assign lat = rsp_ts - ref_ts;

   generate
      if (INCL_BOUND) begin : g_incl
         assign too_late = (lat > BOUND);
      end else begin : g_excl
         assign too_late = (lat >= BOUND);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                          viol_q <= 1'b0;
      else if (chk_en && !ovf_q && too_late) viol_q <= 1'b1;
   end

   // R7
   viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_q) |-> ($past(chk_en) && !$past(ovf_q)));
   // R10
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |=> viol_q);

   initial begin
      bound_param_chk: assert (LAT_BOUND > 0 && LAT_BOUND < (1 << TS_W))
         else $error("lmon_lat_judge: LAT_BOUND out of timestamp range");
   end

endmodule

// File: rtl/lat_pair_mon.sv
module lat_pair_mon
   import lat_mon_pkg::*;
#(
   parameter int TS_W       = 16,
   parameter int DEPTH      = 51,
   parameter int LAT_BOUND  = 25,
   parameter bit INCL_BOUND = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_stb,
   input  logic [TS_W-1:0] req_ts,
   input  logic            rsp_stb,
   input  logic [TS_W-1:0] rsp_ts,
   output logic            lat_viol,
   output logic            ovf_flag,
   output logic            proto_err,
   output logic [1:0]      verdict
);
   logic            rsp_ok, rsp_bypass;
   logic [TS_W-1:0] stored_ts, ref_ts;

   lmon_pair_track #(.DEPTH(DEPTH)) track_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_stb   (req_stb),
      .rsp_stb   (rsp_stb),
      .rsp_ok    (rsp_ok),
      .rsp_bypass(rsp_bypass),
      .ovf_q     (ovf_flag),
      .proto_q   (proto_err)
   );

   lmon_ts_ring #(.TS_W(TS_W), .DEPTH(DEPTH)) ring_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(req_stb),
      .wr_ts(req_ts),
      .rd_en(rsp_ok),
      .rd_ts(stored_ts)
   );

   // A request written this cycle is not yet readable from the store.
   assign ref_ts = rsp_bypass ? req_ts : stored_ts;

   lmon_lat_judge #(.TS_W(TS_W), .LAT_BOUND(LAT_BOUND), .INCL_BOUND(INCL_BOUND)) judge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .chk_en(rsp_ok),
      .ovf_q (ovf_flag),
      .ref_ts(ref_ts),
      .rsp_ts(rsp_ts),
      .viol_q(lat_viol)
   );

   assign verdict = pick_verdict(lat_viol, ovf_flag);

   // R8
   viol_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_viol && $past(verdict) == VERD_UNSAT) |-> verdict == VERD_UNSAT);
   // R6
   inconcl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !lat_viol) |-> verdict == VERD_INCONCL);

endmodule

// File: tb/lat_pair_mon_tb_top.sv
`timescale 1ns/1ps
module lat_pair_mon_tb_top;
   localparam int TS_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_stb = 1'b0, rsp_stb = 1'b0;
   logic [TS_W-1:0] req_ts = '0, rsp_ts = '0;
   logic            lat_viol, ovf_flag, proto_err;
   logic [1:0]      verdict;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lat_pair_mon #(.TS_W(TS_W), .DEPTH(51), .LAT_BOUND(25)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_stb(req_stb), .req_ts(req_ts),
      .rsp_stb(rsp_stb), .rsp_ts(rsp_ts),
      .lat_viol(lat_viol), .ovf_flag(ovf_flag),
      .proto_err(proto_err), .verdict(verdict)
   );

   // {req, req_ts, rsp, rsp_ts, exp_viol, exp_proto}
   localparam int NV = 19;
   localparam logic [35:0] VEC [NV] = '{
      {1'b1, 16'd100,   1'b0, 16'd0,    1'b0, 1'b0}, // R2 request
      {1'b0, 16'd0,     1'b1, 16'd110,  1'b0, 1'b0}, // R2 latency 10
      {1'b1, 16'd200,   1'b0, 16'd0,    1'b0, 1'b0}, // R3
      {1'b1, 16'd205,   1'b0, 16'd0,    1'b0, 1'b0}, // R3
      {1'b0, 16'd0,     1'b1, 16'd220,  1'b0, 1'b0}, // R3 pairs 200
      {1'b0, 16'd0,     1'b1, 16'd229,  1'b0, 1'b0}, // R2 latency 24
      {1'b1, 16'd300,   1'b1, 16'd300,  1'b0, 1'b0}, // R4 zero latency
      {1'b1, 16'd400,   1'b0, 16'd0,    1'b0, 1'b0}, // R4
      {1'b1, 16'd430,   1'b1, 16'd420,  1'b0, 1'b0}, // R4 pairs 400
      {1'b0, 16'd0,     1'b1, 16'd450,  1'b0, 1'b0}, // R4 pairs 430
      {1'b1, 16'd65530, 1'b0, 16'd0,    1'b0, 1'b0}, // R5
      {1'b0, 16'd0,     1'b1, 16'd10,   1'b0, 1'b0}, // R5 wrapped latency 16
      {1'b0, 16'd0,     1'b1, 16'd20,   1'b0, 1'b1}, // R9 unmatched
      {1'b1, 16'd500,   1'b0, 16'd0,    1'b0, 1'b1}, // R9
      {1'b0, 16'd0,     1'b1, 16'd510,  1'b0, 1'b1}, // R9 pairing intact
      {1'b1, 16'd1000,  1'b0, 16'd0,    1'b0, 1'b1}, // R2
      {1'b0, 16'd0,     1'b1, 16'd1025, 1'b1, 1'b1}, // R2 latency 25
      {1'b1, 16'd1100,  1'b0, 16'd0,    1'b1, 1'b1}, // R10
      {1'b0, 16'd0,     1'b1, 16'd1101, 1'b1, 1'b1}  // R10 sticky
   };

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input logic rq, input logic [TS_W-1:0] rqt,
                       input logic rs, input logic [TS_W-1:0] rst);
      @(negedge clk);
      req_stb = rq; req_ts = rqt; rsp_stb = rs; rsp_ts = rst;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step(1'b0, '0, 1'b0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      req_stb = 1'b0; rsp_stb = 1'b0; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 lat_viol", {1'b0, lat_viol}, 2'b00);
      check("R1 ovf_flag", {1'b0, ovf_flag}, 2'b00);
      check("R1 proto_err", {1'b0, proto_err}, 2'b00);
      check("R1 verdict", verdict, 2'b00);

      // Table walk: R2 R3 R4 R5 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [35:0] v;
         v = VEC[i];
         step(v[35], v[34:19], v[18], v[17:2]);
         check($sformatf("R2/R3/R4/R5 row %0d lat_viol", i), {1'b0, lat_viol}, {1'b0, v[1]});
         check($sformatf("R9 row %0d proto_err", i), {1'b0, proto_err}, {1'b0, v[0]});
         check($sformatf("R10 row %0d verdict", i), verdict, v[1] ? 2'b10 : 2'b00);
      end

      // R6 overflow at 51st outstanding request, R7 suppression afterwards
      do_reset();
      for (int k = 0; k < 50; k++) step(1'b1, TS_W'(k), 1'b0, '0);
      check("R6 no overflow at 50 outstanding", {1'b0, ovf_flag}, 2'b00);
      step(1'b1, 16'd50, 1'b0, '0);
      check("R6 overflow flag", {1'b0, ovf_flag}, 2'b01);
      check("R6 verdict inconclusive", verdict, 2'b01);
      step(1'b0, '0, 1'b1, 16'd1000);
      check("R7 late response ignored", {1'b0, lat_viol}, 2'b00);
      check("R7 verdict stays inconclusive", verdict, 2'b01);
      idle();
      check("R10 overflow sticky", {1'b0, ovf_flag}, 2'b01);

      // R8 violation before overflow dominates
      do_reset();
      step(1'b1, 16'd0, 1'b0, '0);
      step(1'b0, '0, 1'b1, 16'd100);
      check("R8 violation recorded", {1'b0, lat_viol}, 2'b01);
      for (int k = 0; k < 51; k++) step(1'b1, TS_W'(200 + k), 1'b0, '0);
      check("R8 overflow reached", {1'b0, ovf_flag}, 2'b01);
      check("R8 verdict unsatisfied", verdict, 2'b10);

      // R1 reset clears sticky flags
      do_reset();
      check("R1 flags cleared", {lat_viol, ovf_flag}, 2'b00);
      check("R1 verdict cleared", verdict, 2'b00);

      finish_run();
   end

endmodule